// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Generator

This block raises a periodic timeout from a one-cycle E-clock enable. A free-running prescaler counts E-clock enables. Each time the count crosses a boundary at the power of two picked by a two-bit rate field, the block sets a sticky timeout flag. A level interrupt request is raised while both that flag and its enable bit are 1.

Only reset restarts the prescaler. Each period therefore runs from the previous timeout, and neither the moment software clears the flag nor the time it takes to service it moves the cadence. Software sees two byte-wide registers, chosen by a one-bit select.

- The control register holds the interrupt enable, the rate field and spare bits for unrelated event sources. The spare bits are kept only as storage.
- The status register holds the timeout flag. Writing 1 to the flag's bit clears it.

With the default `BASE_TAP` of 13, the rates give periods of 2^13, 2^14, 2^15 and 2^16 E cycles. At a 2 MHz E clock these are 4.096, 8.192, 16.384 and 32.768 ms.

Top module: `rt_tick_irq`

## Requirements
- R1: After reset, with rate field value r, the flag first reads 1 right after the 2^(BASE_TAP+r)-th E enable. It reads 0 after every earlier enable.
- R2: With the rate held constant, timeouts follow one another every 2^(BASE_TAP+r) E enables. The spacing does not depend on when, or whether, the flag is cleared.
- R3: A timeout sets the flag. The flag stays 1 until software clears it.
- R4: Writing the status register (select = 1) with bit 6 at 1 clears the flag. A write with bit 6 at 0 leaves the flag unchanged.
- R5: When a timeout and a clearing write fall in the same cycle, the flag ends up 1.
- R6: `irq_o` is 1 exactly while the flag is 1 and the enable bit (control register bit 6) is 1.
- R7: After reset, the control register reads 0x00, the status register reads 0x00 and `irq_o` is 0.
- R8: The prescaler advances only in cycles where `e_en` is 1. Cycles without an enable do not count toward a period.
- R9: If the rate field changes in the middle of a period, the prescaler is not reset. The next timeout comes at the next E enable that takes the running count across a multiple of the newly selected period.
- R10: The control register (select = 0) reads back every bit last written to it. Bits 1:0 are the rate field, bit 6 is the enable, and the remaining bits are storage only. The status register reads the flag in bit 6 and 0 in every other bit, whatever is written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e_en | input | 1 | One-cycle E-clock enable that advances the prescaler |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that `wr_en` and `e_en` are clean single-cycle qualifiers, sampled only at the rising edge. They also take for granted that a clearing write is recognised only from the register select and bit 6 of the write data. The bench drives every input half a cycle away from the rising edge and holds it for exactly one cycle, so each enable and each write counts once. It reduces the prescaler to a 3-bit base tap so that every rate, enable duty and clear latency can be swept in full.

// File: rtl/rti_pkg.sv
`timescale 1ns/1ps
// Shared constants for the periodic timeout generator: register width,
// bit positions that software relies on, and the register select codes.
package rti_pkg;
    localparam int REG_W     = 8;
    localparam int RATE_W    = 2;
    localparam int RATE_LSB  = 0;
    localparam int EN_BIT    = 6;
    localparam int FLAG_BIT  = 6;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_STAT = 1'b1;
endpackage

// File: rtl/rti_prescaler.sv
`timescale 1ns/1ps
// Free-running E-clock prescaler with selectable timeout tap.
// Counts E enables. A timeout pulse is produced on the enable that carries
// the count across a multiple of 2^(BASE_TAP+rate). Only reset restarts it.
// Assumes BASE_TAP >= 1 and that e_en is a single-cycle qualifier.
module rti_prescaler #(
    parameter int BASE_TAP = 13,
    parameter int RATE_W   = 2,
    localparam int NUM_TAPS = 1 << RATE_W,
    localparam int CNT_W    = BASE_TAP + NUM_TAPS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_en,
    input  logic [RATE_W-1:0] rate,
    output logic              tick_o,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [CNT_W-1:0]    cnt_q;
    logic [NUM_TAPS-1:0] tap_full;

    // Advance the running count on each E enable; cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (e_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One boundary detector per selectable tap: low bits all ones.
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign tap_full[t] = &cnt_q[BASE_TAP+t-1:0];
    end

    // Timeout fires on the enable that crosses the selected boundary.
    always_comb begin
        tick_o = e_en & tap_full[rate];
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rti_flag_ctrl.sv
`timescale 1ns/1ps
// Sticky timeout flag. A timeout sets it and a clear request resets it.
// A timeout in the same cycle as a clear leaves the flag set.
// Assumes tick and clr_req are single-cycle qualifiers.
module rti_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr_req,
    output logic flag_o
);
    logic flag_q;

    // Set has priority over clear; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (tick) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rti_regs.sv
`timescale 1ns/1ps
// Software view: the control register (enable, rate, spare storage) and the
// read mux of both registers. It also decodes the write-one-to-clear request
// for the status flag. Assumes wr_en is a single-cycle strobe.
module rti_regs
    import rti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              flag,
    output logic [REG_W-1:0]  rd_data,
    output logic              enable_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              clr_o
);
    logic [REG_W-1:0] ctrl_q;

    // Control register: every bit is writable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && reg_sel == SEL_CTRL) begin
            ctrl_q <= wr_data;
        end
    end

    // Decode fields and the clear request.
    always_comb begin
        enable_o = ctrl_q[EN_BIT];
        rate_o   = ctrl_q[RATE_LSB +: RATE_W];
        clr_o    = wr_en && (reg_sel == SEL_STAT) && wr_data[FLAG_BIT];
    end

    // Read mux: status register shows only the flag.
    always_comb begin
        rd_data = '0;
        if (reg_sel == SEL_CTRL) begin
            rd_data = ctrl_q;
        end else begin
            rd_data[FLAG_BIT] = flag;
        end
    end
endmodule

// File: rtl/rt_tick_irq.sv
`timescale 1ns/1ps
// Top of the periodic timeout generator. It joins the prescaler, the sticky
// flag and the register file, and drives the level interrupt request.
// Assumes a single clock domain and a one-cycle e_en.
module rt_tick_irq #(
    parameter int BASE_TAP = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e_en,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq_o
);
    import rti_pkg::*;
    localparam int CNT_W = BASE_TAP + (1 << RATE_W) - 1;

    logic              tick_w;
    logic              flag_w;
    logic              enable_w;
    logic              clr_w;
    logic [RATE_W-1:0] rate_w;
    logic [CNT_W-1:0]  cnt_w;

    rti_prescaler #(.BASE_TAP(BASE_TAP), .RATE_W(RATE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .e_en(e_en), .rate(rate_w),
        .tick_o(tick_w), .cnt_o(cnt_w)
    );

    rti_flag_ctrl u_flag (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .clr_req(clr_w),
        .flag_o(flag_w)
    );

    rti_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .flag(flag_w), .rd_data(rd_data),
        .enable_o(enable_w), .rate_o(rate_w), .clr_o(clr_w)
    );

    // Level request while the flag and its enable are both set.
    always_comb begin
        irq_o = flag_w & enable_w;
    end
endmodule

// File: rtl/rt_tick_irq_chk.sv
`timescale 1ns/1ps
// Checker for rt_tick_irq, bound into every instance of the top.
module rt_tick_irq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             e_en,
    input logic             reg_sel,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             irq_o,
    input logic             tick,
    input logic             flag,
    input logic             enable,
    input logic [CNT_W-1:0] cnt
);
    logic clr_seen;
    assign clr_seen = wr_en && reg_sel && wr_data[6];

    // R3
    tick_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag);

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_seen) |=> flag);

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr_seen && !tick) |=> !flag);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_seen) |=> flag);

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !tick) |=> !flag);

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !e_en |=> $stable(cnt));

    // R8
    tick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> e_en);

    // R6
    irq_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag && enable));
endmodule

bind rt_tick_irq rt_tick_irq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .e_en(e_en), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .irq_o(irq_o), .tick(tick_w),
    .flag(flag_w), .enable(enable_w), .cnt(cnt_w)
);

// File: tb/rt_tick_irq_tb_top.sv
`timescale 1ns/1ps
module rt_tick_irq_tb_top;
    localparam int TB_BASE = 3;
    localparam int CNT_MOD = 1 << (TB_BASE + 3);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference state derived from the requirements.
    int       m_cnt  = 0;
    bit       m_flag = 0;
    bit [7:0] m_ctrl = 8'h00;

    always #2 clk = ~clk;

    rt_tick_irq #(.BASE_TAP(TB_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .e_en(e_en), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int period(input bit [1:0] r);
        return 1 << (TB_BASE + r);
    endfunction

    // Compare both registers and the request against the reference.
    task automatic compare(input string tag);
        reg_sel = 1'b0;
        #0.4;
        chk({tag, " ctrl"}, rd_data, m_ctrl);
        chk({tag, " irq"}, irq_o, m_flag & m_ctrl[6]);
        reg_sel = 1'b1;
        #0.4;
        chk({tag, " stat"}, rd_data, {1'b0, m_flag, 6'b0});
    endtask

    // One clock: drive at the falling edge, update the reference, compare.
    task automatic step(input bit e, input bit w, input bit s,
                        input bit [7:0] d, input string tag);
        bit tk;
        @(negedge clk);
        e_en = e; wr_en = w; reg_sel = s; wr_data = d;
        @(posedge clk);
        tk = e && (((m_cnt + 1) % period(m_ctrl[1:0])) == 0);
        if (tk) m_flag = 1;
        else if (w && s && d[6]) m_flag = 0;
        if (e) m_cnt = (m_cnt + 1) % CNT_MOD;
        if (w && !s) m_ctrl = d;
        #0.5;
        e_en = 1'b0; wr_en = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; e_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_flag = 0; m_ctrl = 8'h00;
    endtask

    function automatic bit flag_now();
        return m_flag;
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        bit seen;
        do_reset();
        // R7: reset values
        compare("R7");
        chk("R7 irq idle", irq_o, 0);

        // R1: first timeout after one full period, every rate
        for (int r = 0; r < 4; r++) begin
            do_reset();
            step(0, 1, 0, {6'b0, r[1:0]}, "R1 setup");
            for (int k = 1; k <= period(r[1:0]); k++) begin
                step(1, 0, 0, 8'h00, "R1");
                chk("R1 first set", rd_data[6], (k >= period(r[1:0])) ? 1 : 0);
            end
        end

        // R2 / R8 / R6: sweep rate x enable duty x clear latency
        for (int r = 0; r < 4; r++) begin
            for (int duty = 1; duty <= 3; duty++) begin
                do_reset();
                step(0, 1, 0, {1'b0, r[0], 4'b0, r[1:0]}, "R6 setup");
                for (int c = 0; c < 3 * period(r[1:0]) * duty; c++) begin
                    bit e = ((c % duty) == 0);
                    bit clr = flag_now() && ((c % 5) == duty);
                    step(e, clr, 1, clr ? 8'h40 : 8'h00, "R2");
                end
            end
        end

        // R8: no enables, no progress
        do_reset();
        for (int c = 0; c < 40; c++) step(0, 0, 0, 8'h00, "R8");
        chk("R8 idle flag", rd_data[6], 0);

        // R5: clear lands on the timeout cycle
        do_reset();
        for (int c = 0; c < 7; c++) step(1, 0, 0, 8'h00, "R5 run");
        step(1, 1, 1, 8'h40, "R5");
        chk("R5 set wins", rd_data[6], 1);

        // R4: writing 0 to bit 6 keeps the flag; writing 1 clears it
        step(0, 1, 1, 8'hBF, "R4 zero");
        chk("R4 kept", rd_data, 8'h40);
        step(0, 1, 1, 8'h40, "R4 one");
        chk("R4 cleared", rd_data, 8'h00);

        // R3: sticky across many enables without a clear
        for (int c = 0; c < 20; c++) step(1, 0, 0, 8'h00, "R3");
        chk("R3 sticky", rd_data[6], 1);

        // R6: enable toggled while the flag is set
        step(0, 1, 0, 8'h40, "R6 on");
        chk("R6 irq on", irq_o, 1);
        step(0, 1, 0, 8'h00, "R6 off");
        chk("R6 irq off", irq_o, 0);

        // R9: shorter rate mid-period; count 20, next 8-boundary after 4
        do_reset();
        step(0, 1, 0, 8'h02, "R9 setup");
        for (int c = 0; c < 20; c++) step(1, 0, 0, 8'h00, "R9 run");
        step(0, 1, 0, 8'h00, "R9 switch");
        for (int c = 1; c <= 4; c++) begin
            step(1, 0, 0, 8'h00, "R9");
            chk("R9 short", rd_data[6], (c == 4) ? 1 : 0);
        end
        // R9: longer rate mid-period; count 5, next 16-boundary after 11
        do_reset();
        for (int c = 0; c < 5; c++) step(1, 0, 0, 8'h00, "R9 run");
        step(0, 1, 0, 8'h01, "R9 switch");
        seen = 0;
        for (int c = 1; c <= 11; c++) begin
            step(1, 0, 0, 8'h00, "R9");
            chk("R9 long", rd_data[6], (c == 11) ? 1 : 0);
        end

        // R10: control storage and status reserved bits
        do_reset();
        for (int v = 0; v < 256; v += 37) begin
            step(0, 1, 0, v[7:0] & 8'hBC, "R10 ctrl");
            chk("R10 ctrl rb", m_ctrl, v[7:0] & 8'hBC);
            step(0, 1, 1, v[7:0] & 8'hBF, "R10 stat");
        end
        chk("R10 stat zero", rd_data, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule